// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs PHY management transactions from one 32-bit maintenance word. Software writes the whole frame into the word: start code, opcode, PHY address, register number, turnaround pattern and data. If the engine is idle and management is enabled, it sends the word out most significant bit first on the serial management pair. An optional run of 32 ones can come before the word. The management clock is the system clock divided by one of two even ratios.

When the opcode in the word is a read, the engine stops driving the data line from the second turnaround bit up to the last data bit. It samples the sixteen bits the PHY returns. At the end of the frame it writes them into the low half of the same maintenance word. The upper half keeps the header that software wrote. The usage rule is this: wait until `idle` is high, write the word, then wait for `idle` again before reading the result.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, `idle` is 1, `reg_rd_data` is 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: A write (`wr_en`) is accepted when `idle` is 1 and `mgmt_en` is 1. On the next cycle `reg_rd_data` equals the written word and `idle` is 0.
- R3: A write while `idle` is 0 is ignored. The register and the frame in progress are unchanged, and `idle` stays 0.
- R4: A write while `mgmt_en` is 0 is ignored. The register is unchanged, `idle` stays 1 and `mdc` stays 0.
- R5: Each half period of `mdc` lasts DIV_A/2 system cycles when `div_sel` is 0, and DIV_B/2 cycles when it is 1 (24 and 32 by default).
- R6: With `pre_en` set, the frame is 32 ones followed by word bits 31 down to 0. `mdio_o` changes only while `mdc` is low, and is valid at each rising `mdc` edge.
- R7: With `pre_en` clear, the first bit presented at a rising `mdc` edge is word bit 31, and the frame has 32 bits.
- R8: When word bits 29:28 are 2'b10 (read), `mdio_oe` is 0 for the bits at word positions 16 down to 0. It is 1 for every other bit of the frame.
- R9: After a read frame, `reg_rd_data[15:0]` holds the 16 bits sampled from `mdio_i` at the rising `mdc` edges of word positions 15 down to 0, first sample in bit 15. Bits 31:16 keep the written value.
- R10: For any opcode other than 2'b10, `mdio_oe` is 1 for the whole frame and the register still holds the written word afterwards.
- R11: `idle` stays 0 for exactly (frame bits) x (divide ratio) cycles after the accepting edge. While `idle` is 1, `mdc` and `mdio_oe` are 0.
- R12: Clearing `mgmt_en` during a frame ends it. On the next cycle `idle` is 1 and `mdc` and `mdio_oe` are 0. Read data is not committed, so the register keeps the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 1 | Divider choice: 0 = DIV_A, 1 = DIV_B |
| pre_en | input | 1 | Send 32-bit preamble before the word |
| wr_en | input | 1 | Maintenance word write strobe |
| wr_data | input | 32 | Frame word to send |
| reg_rd_data | output | 32 | Current maintenance word, including read data |
| idle | output | 1 | 1 when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data out toward the PHY |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Data in from the PHY |

## Verification
The assertions assume that `div_sel` and `pre_en` do not change while a frame is in progress. They also assume that the PHY changes `mdio_i` only after a falling `mdc` edge. The bench keeps both settings steady from the write until `idle` returns. It updates `mdio_i` on the cycle after each rising edge it observes, well before the next sampling point. Random frame words always carry start code 01 and a read or write opcode. The busy-write and disable cases are driven only at chosen points inside a frame.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_FRAME = 2'd2
    } mdio_state_e;

    // opcode value (word bits 29:28) that turns the line around for a read
    localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_A = 48,
    parameter int DIV_B = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int HALF_A   = DIV_A / 2;
    localparam int HALF_B   = DIV_B / 2;
    localparam int MAX_HALF = (HALF_A > HALF_B) ? HALF_A : HALF_B;
    localparam int CW       = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;
    localparam logic [CW-1:0] LIM_A = CW'(HALF_A - 1);
    localparam logic [CW-1:0] LIM_B = CW'(HALF_B - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_s;

    div_s cur_q, nxt_d;
    logic [CW-1:0] lim;
    logic          at_lim;

    always_comb begin
        lim    = sel ? LIM_B : LIM_A;
        at_lim = (cur_q.cnt == lim);
        nxt_d  = cur_q;
        if (!run) begin
            nxt_d.cnt = '0;
            nxt_d.mdc = 1'b0;
        end else if (at_lim) begin
            nxt_d.cnt = '0;
            nxt_d.mdc = ~cur_q.mdc;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign mdc  = cur_q.mdc;
    assign rise = run && at_lim && !cur_q.mdc;
    assign fall = run && at_lim &&  cur_q.mdc;

endmodule

// File: rtl/mdio_serializer.sv
module mdio_serializer
    import mdio_frame_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic              pre_en,
    input  logic [WORD_W-1:0] word,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              commit,
    output logic [DATA_W-1:0] cap_data
);
    localparam int PW    = $clog2(WORD_W);
    localparam int PCW   = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
    localparam int OP_HI = WORD_W - 3;
    localparam logic [PW-1:0]  TOP_POS  = PW'(WORD_W - 1);
    localparam logic [PW-1:0]  DATA_TOP = PW'(DATA_W);
    localparam logic [PCW-1:0] PRE_LAST = PCW'(PRE_LEN - 1);

    typedef struct packed {
        mdio_state_e       state;
        logic [PCW-1:0]    pre_cnt;
        logic [PW-1:0]     pos;
        logic [WORD_W-1:0] shreg;
        logic [DATA_W-1:0] cap;
        logic              rd;
    } ser_s;

    ser_s cur_q, nxt_d;
    logic done;

    always_comb begin
        nxt_d = cur_q;
        done  = 1'b0;
        if (!en) begin
            nxt_d.state = ST_IDLE;
        end else begin
            case (cur_q.state)
                ST_IDLE: begin
                    if (start) begin
                        nxt_d.state   = pre_en ? ST_PRE : ST_FRAME;
                        nxt_d.pre_cnt = '0;
                        nxt_d.pos     = TOP_POS;
                        nxt_d.shreg   = word;
                        nxt_d.rd      = (word[OP_HI:OP_HI-1] == OP_READ);
                        nxt_d.cap     = '0;
                    end
                end
                ST_PRE: begin
                    if (fall) begin
                        if (cur_q.pre_cnt == PRE_LAST) nxt_d.state = ST_FRAME;
                        else nxt_d.pre_cnt = cur_q.pre_cnt + 1'b1;
                    end
                end
                ST_FRAME: begin
                    // PHY data is taken just before MDC rises
                    if (rise && cur_q.rd && (cur_q.pos < DATA_TOP))
                        nxt_d.cap = {cur_q.cap[DATA_W-2:0], mdio_i};
                    if (fall) begin
                        if (cur_q.pos == '0) begin
                            nxt_d.state = ST_IDLE;
                            done        = 1'b1;
                        end else begin
                            nxt_d.pos   = cur_q.pos - 1'b1;
                            nxt_d.shreg = {cur_q.shreg[WORD_W-2:0], 1'b0};
                        end
                    end
                end
                default: nxt_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy     = (cur_q.state != ST_IDLE);
    assign mdio_o   = (cur_q.state == ST_FRAME) ? cur_q.shreg[WORD_W-1] : 1'b1;
    assign mdio_oe  = busy && !(cur_q.rd && (cur_q.state == ST_FRAME) && (cur_q.pos <= DATA_TOP));
    assign commit   = done && cur_q.rd;
    assign cap_data = cur_q.cap;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
    parameter int DIV_A   = 48,
    parameter int DIV_B   = 64,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mgmt_en,
    input  logic        div_sel,
    input  logic        pre_en,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] reg_rd_data,
    output logic        idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int WORD_W = 32;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic [WORD_W-1:0] mreg;
    } top_s;

    top_s cur_q, nxt_d;
    logic busy, accept, commit, rise, fall;
    logic [DATA_W-1:0] cap_data;

    assign accept = wr_en && mgmt_en && !busy;

    mdio_clk_div #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy && mgmt_en),
        .sel   (div_sel),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_serializer #(
        .WORD_W  (WORD_W),
        .DATA_W  (DATA_W),
        .PRE_LEN (PRE_LEN)
    ) i_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mgmt_en),
        .start    (accept),
        .pre_en   (pre_en),
        .word     (wr_data),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .commit   (commit),
        .cap_data (cap_data)
    );

    always_comb begin
        nxt_d = cur_q;
        if (accept)      nxt_d.mreg = wr_data;
        else if (commit) nxt_d.mreg[DATA_W-1:0] = cap_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign reg_rd_data = cur_q.mreg;
    assign idle        = !busy;

endmodule

// File: rtl/mdio_frame_checker.sv
module mdio_frame_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mgmt_en,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] reg_rd_data,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && wr_en && mgmt_en) |=> (!idle && reg_rd_data == $past(wr_data))); // R2

    AST_BUSY_HEADER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && wr_en) |=> (reg_rd_data[31:16] == $past(reg_rd_data[31:16]))); // R3

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_en |=> idle); // R12

    AST_DATA_STABLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o)); // R6

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mdc); // R11

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mdio_oe); // R11
endmodule

bind mdio_frame_engine mdio_frame_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mgmt_en     (mgmt_en),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .reg_rd_data (reg_rd_data),
    .idle        (idle),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
);

// File: tb/test_mdio_frame_engine.sv
module test_mdio_frame_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_en = 1'b0;
    logic        div_sel = 1'b0;
    logic        pre_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_frame_engine i_mdio_frame_engine (
        .clk (clk), .rst_n (rst_n), .mgmt_en (mgmt_en), .div_sel (div_sel),
        .pre_en (pre_en), .wr_en (wr_en), .wr_data (wr_data),
        .reg_rd_data (reg_rd_data), .idle (idle), .mdc (mdc),
        .mdio_o (mdio_o), .mdio_oe (mdio_oe), .mdio_i (mdio_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_read(input logic [31:0] w);
        return w[29:28] == 2'b10;
    endfunction

    function automatic bit exp_bit(input logic [31:0] w, input bit pre, input int idx);
        int k;
        if (pre && idx < 32) return 1'b1;
        k = pre ? idx - 32 : idx;
        return w[31-k];
    endfunction

    function automatic bit exp_oe(input logic [31:0] w, input bit pre, input int idx);
        int k;
        if (pre && idx < 32) return 1'b1;
        k = 31 - (pre ? idx - 32 : idx);
        return !(is_read(w) && k <= 16);
    endfunction

    function automatic logic [31:0] exp_reg(input logic [31:0] w, input logic [15:0] phy);
        return is_read(w) ? {w[31:16], phy} : w;
    endfunction

    task automatic run_frame(input logic [31:0] word, input bit pre, input bit sel,
                             input logic [15:0] phy, input bit inject);
        int half, nb, pre_n, nbits, busy_cyc, last_tr, bit_err, oe_err, per_err, chg_err, k;
        bit prev_mdc, prev_o;
        half  = sel ? 32 : 24;
        pre_n = pre ? 32 : 0;
        nb    = pre_n + 32;
        @(negedge clk);
        pre_en = pre; div_sel = sel; wr_data = word; wr_en = 1'b1; mdio_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(!idle && reg_rd_data == word, "R2", "write accepted", reg_rd_data, word);
        nbits = 0; busy_cyc = 0; last_tr = 0; bit_err = 0; oe_err = 0; per_err = 0; chg_err = 0;
        prev_mdc = mdc; prev_o = mdio_o;
        for (int c = 0; c < nb * half * 2 + 20; c++) begin
            if (idle) break;
            busy_cyc++;
            if (mdc != prev_mdc) begin
                if (c - last_tr != half) per_err++;
                last_tr = c;
            end
            if (mdc && prev_mdc && mdio_o != prev_o) chg_err++;
            if (mdc && !prev_mdc) begin
                if (nbits < nb) begin
                    if (mdio_o != exp_bit(word, pre, nbits)) bit_err++;
                    if (mdio_oe != exp_oe(word, pre, nbits)) oe_err++;
                end
                nbits++;
                k = 31 - (nbits - pre_n);
                mdio_i = (nbits >= pre_n && k >= 0 && k <= 15) ? phy[k] : 1'b1;
            end
            if (inject && c == 100) begin
                wr_data = ~word; wr_en = 1'b1;
            end
            if (inject && c == 101) begin
                wr_en = 1'b0;
                check(!idle && reg_rd_data == word, "R3", "busy write ignored", reg_rd_data, word);
            end
            prev_mdc = mdc; prev_o = mdio_o;
            @(negedge clk);
        end
        check(nbits == nb, pre ? "R6" : "R7", "bit count", nbits, nb);
        check(bit_err == 0, pre ? "R6" : "R7", "bit value mismatches", bit_err, 0);
        check(chg_err == 0, "R6", "mdio change while mdc high", chg_err, 0);
        check(oe_err == 0, is_read(word) ? "R8" : "R10", "output enable mismatches", oe_err, 0);
        check(per_err == 0, "R5", "half period mismatches", per_err, 0);
        check(busy_cyc == nb * half * 2, "R11", "busy cycles", busy_cyc, nb * half * 2);
        check(idle && !mdc && !mdio_oe, "R11", "idle outputs", {idle, mdc, mdio_oe}, 3'b100);
        check(reg_rd_data == exp_reg(word, phy), is_read(word) ? "R9" : "R10",
              "final register", reg_rd_data, exp_reg(word, phy));
    endtask

    function automatic logic [31:0] make_word(input bit rd, input logic [4:0] pa,
                                              input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++; failures++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle && reg_rd_data == 32'h0 && !mdc && !mdio_oe, "R1", "reset state",
              {reg_rd_data[27:0], idle, mdc, mdio_oe}, 32'h1 << 2);
        mgmt_en = 1'b1;

        // directed corners
        run_frame(make_word(1'b1, 5'd1, 5'd2, 16'h0000), 1'b0, 1'b0, 16'hA5C3, 1'b0);
        run_frame(make_word(1'b0, 5'd31, 5'd0, 16'h1234), 1'b1, 1'b1, 16'h0000, 1'b0);
        run_frame(make_word(1'b1, 5'd7, 5'd31, 16'hBEEF), 1'b1, 1'b1, 16'h0001, 1'b1);
        run_frame(make_word(1'b1, 5'd0, 5'd1, 16'h0000), 1'b0, 1'b1, 16'hFFFF, 1'b0);

        // random frames
        for (int i = 0; i < 6; i++) begin
            w = make_word(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom));
            run_frame(w, 1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom));
        end

        // R4: write with management disabled
        w = reg_rd_data;
        @(negedge clk);
        mgmt_en = 1'b0; wr_data = 32'h6ABC_1234; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(idle && reg_rd_data == w, "R4", "disabled write ignored", reg_rd_data, w);
        repeat (60) @(negedge clk);
        check(idle && !mdc, "R4", "no mdc while disabled", {idle, mdc}, 2'b10);

        // R12: abort a read frame by clearing enable
        mgmt_en = 1'b1;
        w = make_word(1'b1, 5'd3, 5'd4, 16'h5555);
        @(negedge clk);
        pre_en = 1'b0; div_sel = 1'b0; wr_data = w; wr_en = 1'b1; mdio_i = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (1000) @(negedge clk);
        check(!idle, "R12", "still busy before abort", idle, 0);
        mgmt_en = 1'b0;
        @(negedge clk);
        check(idle && !mdc && !mdio_oe, "R12", "abort outputs", {idle, mdc, mdio_oe}, 3'b100);
        check(reg_rd_data == w, "R12", "no partial commit", reg_rd_data, w);
        mgmt_en = 1'b1; mdio_i = 1'b1;
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule